// File: doc/BRIEF.md
# Motor Startup and Overcurrent Supervisor

This block watches a brushless motor during spin-up and while it runs, and raises fault flags that the drive uses to remove gate power. A start strobe opens a fixed-length startup window. During that window the three Hall sensor lines are sampled at a regular interval, after a two-flop synchronizer, and every difference between one sample and the next adds one to an activity count. The count is visible at the ports. When the window timer reaches its programmable limit, the startup alarm is raised.

The block also receives a stream of digitized bus-current samples, each marked by a valid strobe. It compares each sample with a programmable current limit. If the current stays above the limit for a debounce delay, measured in clock cycles, the overcurrent alarm is raised. A sample at or below the limit restarts that delay. Both alarms stay set until reset, or until the next start strobe clears them.

The default parameters assume a 25 MHz clock, a Hall sample on every cycle, a 75,000,000-cycle startup window (3 s) and a 50,000-cycle trip delay (2 ms).

Top module: `motor_fault_supervisor`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first cycle after it, both alarms are low and the Hall change count is zero.
- R2: Within the startup window, each change of the synchronized Hall code between two consecutive samples increments the count by exactly one. A Hall code that is held steady adds nothing.
- R3: Hall changes that occur before the first start strobe, or after the startup window has ended, leave the count unchanged.
- R4: The startup alarm is low STARTUP_LIMIT-1 cycles after the clock edge that captures the start strobe, and high STARTUP_LIMIT cycles after it.
- R5: Once high, the startup alarm stays high until reset or a start strobe.
- R6: The Hall change count saturates at its all-ones value (15 when the count is 4 bits wide) and does not wrap.
- R7: A current sample counts as over the limit only when it is strictly greater than current_limit (unsigned compare). A sample equal to the limit never trips the alarm.
- R8: After a valid sample above the limit, with no later valid sample at or below it, the overcurrent alarm is low TRIP_DELAY-1 cycles after the capturing edge and high TRIP_DELAY cycles after it.
- R9: A valid sample at or below the limit, captured before the delay completes, restarts the delay. The alarm then needs a further TRIP_DELAY cycles from the next sample that is over the limit.
- R10: The overcurrent alarm stays high until reset or a start strobe. A start strobe clears both alarms and the count on the next cycle.
- R11: adc_data is ignored whenever adc_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that opens the startup window and clears both alarms |
| hall | input | HALL_W (3) | Raw Hall sensor lines, asynchronous to clk |
| adc_data | input | ADC_W (12) | Bus-current sample, unsigned |
| adc_valid | input | 1 | Marks adc_data as a new sample |
| current_limit | input | ADC_W (12) | Overcurrent threshold, unsigned |
| startup_alarm | output | 1 | Sticky flag: the startup window timer reached its limit |
| overcurrent_alarm | output | 1 | Sticky flag: the current stayed over the limit for the trip delay |
| hall_changes | output | CNT_W (8) | Saturating count of Hall code changes within the current window |

## Verification
The embedded properties check, on every cycle, that both alarms stay set until a start strobe arrives. They also check that the count never decreases between starts, that it is frozen outside the startup window, that the over-limit flag moves only on a valid sample, and that the overcurrent alarm can rise only while the over-limit flag is set. The exact cycle on which each alarm rises can only be shown by the bench's scenarios. The same holds for the restart of the delay by a sample under the limit, the strict-greater compare at the limit value, saturation of the count, and the number of changes counted for a given Hall sequence.

// File: rtl/mfs_pkg.sv
// Package: shared types for the motor fault supervisor.
// Assumes: nothing beyond standard SystemVerilog.
package mfs_pkg;

    // Phases of the startup watch window
    typedef enum logic [1:0] {
        WIN_IDLE    = 2'd0,
        WIN_WATCH   = 2'd1,
        WIN_EXPIRED = 2'd2
    } win_state_t;

endpackage

// File: rtl/mfs_hall_sync.sv
// Module: multi-stage synchronizer for a bus of slow, independent sensor lines.
// Assumes: each line changes rarely compared with clk. Bits are resynchronized
// one by one, so a code change can be seen across two cycles. The downstream
// counter tolerates this on a Gray-coded Hall sequence.
module mfs_hall_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw lines into the first flop stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                // Shift the value on through the remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/mfs_hall_activity.sv
// Module: startup window timer, Hall change counter and startup alarm.
// Assumes: hall_s is already synchronized to clk. A start strobe always
// reopens the window. The count saturates at all ones.
module mfs_hall_activity
    import mfs_pkg::*;
#(
    parameter int          HALL_W        = 3,
    parameter int          CNT_W         = 8,
    parameter int unsigned STARTUP_LIMIT = 75_000_000,
    parameter int unsigned SAMPLE_DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALL_W-1:0] hall_s,
    output logic              startup_alarm,
    output logic [CNT_W-1:0]  change_count
);

    localparam int TMR_W = $clog2(STARTUP_LIMIT + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STARTUP_LIMIT - 1);

    win_state_t         state_q;
    logic [TMR_W-1:0]   timer_q;
    logic               alarm_q;
    logic [HALL_W-1:0]  prev_q;
    logic [CNT_W-1:0]   count_q;
    logic               tick;

    generate
        if (SAMPLE_DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int DIV_W = $clog2(SAMPLE_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
            logic [DIV_W-1:0] div_q;
            // Free-running sample divider, realigned by each start strobe
            always_ff @(posedge clk) begin
                if (!rst_n || start)     div_q <= '0;
                else if (div_q == DIV_LAST) div_q <= '0;
                else                     div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DIV_LAST);
        end
    endgenerate

    // Window sequencing: open on start, run the timer, expire at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            timer_q <= '0;
            alarm_q <= 1'b0;
        end else if (start) begin
            state_q <= WIN_WATCH;
            timer_q <= '0;
            alarm_q <= 1'b0;
        end else if (state_q == WIN_WATCH) begin
            if (timer_q == TMR_LAST) begin
                state_q <= WIN_EXPIRED;
                alarm_q <= 1'b1;
            end else begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    // Hall sampling: compare each sample with the previous one and count differences
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            count_q <= '0;
        end else if (start) begin
            prev_q  <= hall_s;
            count_q <= '0;
        end else if (state_q == WIN_WATCH && tick) begin
            prev_q <= hall_s;
            if (hall_s != prev_q && count_q != '1)
                count_q <= count_q + 1'b1;
        end
    end

    assign startup_alarm = alarm_q;
    assign change_count  = count_q;

    // R5
    su_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !start) |=> alarm_q);

    // R3
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WIN_WATCH && !start) |=> $stable(count_q));

    // R6
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (count_q >= $past(count_q)));

    // R4
    su_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> (state_q == WIN_EXPIRED));

endmodule

// File: rtl/mfs_overcurrent.sv
// Module: delayed overcurrent trip on a stream of current samples.
// Assumes: samples are unsigned. The delay is counted in clk cycles from the
// edge that captures the first sample over the limit.
module mfs_overcurrent #(
    parameter int          ADC_W      = 12,
    parameter int unsigned TRIP_DELAY = 50_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] current_limit,
    output logic             oc_alarm
);

    localparam int DLY_W = $clog2(TRIP_DELAY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(TRIP_DELAY - 1);
    localparam logic [DLY_W-1:0] DLY_FULL = DLY_W'(TRIP_DELAY);

    logic             over_q;
    logic [DLY_W-1:0] dly_q;
    logic             alarm_q;
    logic             above;
    logic             clear_now;

    // Strict compare, and the flag that a valid sample under the limit is present
    always_comb begin
        above     = adc_data > current_limit;
        clear_now = adc_valid && !above;
    end

    // Hold the over/under verdict of the last valid sample
    always_ff @(posedge clk) begin
        if (!rst_n || start) over_q <= 1'b0;
        else if (adc_valid)  over_q <= above;
    end

    // Delay counter: runs while over, restarts on a sample under the limit
    always_ff @(posedge clk) begin
        if (!rst_n || start)                dly_q <= '0;
        else if (clear_now)                 dly_q <= '0;
        else if (over_q && dly_q != DLY_FULL) dly_q <= dly_q + 1'b1;
    end

    // Sticky trip once the delay completes
    always_ff @(posedge clk) begin
        if (!rst_n || start) alarm_q <= 1'b0;
        else if (over_q && !clear_now && dly_q == DLY_LAST) alarm_q <= 1'b1;
    end

    assign oc_alarm = alarm_q;

    // R10
    oc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !start) |=> alarm_q);

    // R8
    oc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(over_q));

    // R11
    oc_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_valid && !start) |=> $stable(over_q));

endmodule

// File: rtl/motor_fault_supervisor.sv
// Module: top of the motor startup and overcurrent supervisor.
// Assumes: hall is asynchronous to clk and goes through a two-flop synchronizer.
// adc_data and current_limit are synchronous to clk.
module motor_fault_supervisor #(
    parameter int          HALL_W        = 3,
    parameter int          ADC_W         = 12,
    parameter int          CNT_W         = 8,
    parameter int unsigned STARTUP_LIMIT = 75_000_000,
    parameter int unsigned TRIP_DELAY    = 50_000,
    parameter int unsigned SAMPLE_DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALL_W-1:0] hall,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  current_limit,
    output logic              startup_alarm,
    output logic              overcurrent_alarm,
    output logic [CNT_W-1:0]  hall_changes
);

    logic [HALL_W-1:0] hall_s;

    mfs_hall_sync #(.W(HALL_W), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (hall),
        .dout  (hall_s)
    );

    mfs_hall_activity #(
        .HALL_W        (HALL_W),
        .CNT_W         (CNT_W),
        .STARTUP_LIMIT (STARTUP_LIMIT),
        .SAMPLE_DIV    (SAMPLE_DIV)
    ) i_activity (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .hall_s        (hall_s),
        .startup_alarm (startup_alarm),
        .change_count  (hall_changes)
    );

    mfs_overcurrent #(
        .ADC_W      (ADC_W),
        .TRIP_DELAY (TRIP_DELAY)
    ) i_oc (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .adc_data      (adc_data),
        .adc_valid     (adc_valid),
        .current_limit (current_limit),
        .oc_alarm      (overcurrent_alarm)
    );

endmodule

// File: tb/test_motor_fault_supervisor.sv
module test_motor_fault_supervisor;

    localparam int HALL_W = 3;
    localparam int ADC_W  = 10;
    localparam int CNT_W  = 4;
    localparam int LIMIT  = 100;
    localparam int TRIP   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [HALL_W-1:0] hall = 3'b101;
    logic [ADC_W-1:0]  adc_data = '0;
    logic              adc_valid = 1'b0;
    logic [ADC_W-1:0]  current_limit = 10'd500;
    logic              startup_alarm;
    logic              overcurrent_alarm;
    logic [CNT_W-1:0]  hall_changes;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    sel;   // 0 startup alarm, 1 overcurrent alarm, 2 count
        int    exp;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    motor_fault_supervisor #(
        .HALL_W(HALL_W), .ADC_W(ADC_W), .CNT_W(CNT_W),
        .STARTUP_LIMIT(LIMIT), .TRIP_DELAY(TRIP), .SAMPLE_DIV(1)
    ) i_motor_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .start(start), .hall(hall),
        .adc_data(adc_data), .adc_valid(adc_valid), .current_limit(current_limit),
        .startup_alarm(startup_alarm), .overcurrent_alarm(overcurrent_alarm),
        .hall_changes(hall_changes)
    );

    // Monitor: pop expectations and compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it = sb_q.pop_front();
                act = (it.sel == 0) ? int'(startup_alarm) :
                      (it.sel == 1) ? int'(overcurrent_alarm) : int'(hall_changes);
                checks++;
                if (act != it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string req, int sel, int exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic adc_sample(int v);
        adc_data = ADC_W'(v);
        adc_valid = 1'b1;
        step(1);
        adc_valid = 1'b0;
    endtask

    task automatic finish_run();
        step(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver
    initial begin
        logic [2:0] seq [6];
        seq[0] = 3'b001; seq[1] = 3'b011; seq[2] = 3'b010;
        seq[3] = 3'b110; seq[4] = 3'b100; seq[5] = 3'b101;

        step(3);
        expect_val("R1 reset startup", 0, 0);
        expect_val("R1 reset oc", 1, 0);
        expect_val("R1 reset count", 2, 0);
        rst_n = 1'b1;
        step(1);
        expect_val("R1 after reset count", 2, 0);

        // R3: changes before any start are ignored
        hall = 3'b001; step(4);
        hall = 3'b101; step(6);
        expect_val("R3 before start", 2, 0);

        // R2/R4: six Gray steps inside the window, then the exact expiry edge
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            hall = seq[i];
            step(4);
        end
        expect_val("R2 six changes", 2, 6);
        step(LIMIT - 1 - 24);
        expect_val("R4 before limit", 0, 0);
        step(1);
        expect_val("R4 at limit", 0, 1);

        // R3: after expiry, changes leave the count alone
        hall = 3'b001; step(6);
        expect_val("R3 after window", 2, 6);
        step(10);
        expect_val("R5 sticky startup", 0, 1);

        // R10/R6: restart clears, then saturate the count
        pulse_start();
        expect_val("R10 start clears startup", 0, 0);
        expect_val("R10 start clears count", 2, 0);
        for (int i = 0; i < 20; i++) begin
            hall = (i % 2 == 0) ? 3'b011 : 3'b001;
            step(3);
        end
        step(3);
        expect_val("R6 saturation", 2, 15);

        // R7: sample equal to the limit never trips
        adc_sample(500);
        step(TRIP + 2);
        expect_val("R7 equal limit", 1, 0);

        // R11: high data without valid is ignored
        adc_data = 10'd900;
        step(TRIP + 4);
        expect_val("R11 no valid", 1, 0);

        // R8: exact trip cycle
        adc_sample(700);
        step(TRIP - 1);
        expect_val("R8 before delay", 1, 0);
        step(1);
        expect_val("R8 at delay", 1, 1);

        // R10: sticky after current drops, cleared by start
        adc_sample(100);
        step(5);
        expect_val("R10 oc sticky", 1, 1);
        pulse_start();
        expect_val("R10 start clears oc", 1, 0);

        // R9: a sample under the limit restarts the delay
        adc_sample(700);
        step(TRIP - 3);
        adc_sample(200);
        expect_val("R9 under sample blocks trip", 1, 0);
        adc_sample(800);
        step(TRIP - 1);
        expect_val("R9 restarted before delay", 1, 0);
        step(1);
        expect_val("R9 restarted at delay", 1, 1);

        done = 1'b1;
        finish_run();
    end

endmodule